// File: doc/BRIEF.md
# Extended Bank Register File

This block holds the bank numbers of a cartridge bank-switching controller. The CPU writes it through two ports in the $8000-$9FFF window: a select port that picks one of twelve bank registers and sets two window-swap bits, and a data port that loads the picked register. From the stored values the block forms, with no clock delay, the 8 KiB PRG bank for the CPU window being accessed and the 1 KiB CHR bank for the PPU window being fetched.

In normal mode, six registers drive CHR: two 2 KiB banks and four 1 KiB banks. Two registers drive PRG, and the remaining two PRG windows hold the last two banks. In extended mode, which an outside register bit turns on, four more registers come into use. All eight CHR windows become independent 1 KiB banks and all four PRG windows become selectable. The address decode keeps A1 as well as A0, so two of the four port aliases in each 8 KiB window do nothing.

Top module: `xbank_regfile`

## Requirements
- R1: After reset, registers 0 to 11 hold $00, $02, $04, $05, $06, $07, $00, $01, $FE, $FF, $FF, $FF. The select value is $00: index 0, no PRG swap, no CHR swap.
- R2: A write is decoded on the CPU address ANDed with $E003. A result of $8000 loads the select port and $8001 loads the data port. Every other address, $A001 included, changes nothing.
- R3: A write whose masked address is $8002 or $8003 ($9FFE and $9FFF among them) leaves all registers and the select value unchanged.
- R4: Select bits 3:0 name the target register. When the index is 12 to 15, a data write changes no register.
- R5: In extended mode, PPU windows A12:A10 = 0..7 take their 1 KiB bank from registers 0, 10, 1, 11, 2, 3, 4, 5 in that order.
- R6: Select bit 7 set inverts PPU A12 before the CHR lookup. This swaps the $0000 and $1000 halves in both modes.
- R7: In extended mode, CPU windows A14:A13 = 0..3 take registers 6, 7, 8, 9. Select bit 6 set swaps the sources of windows 0 and 2.
- R8: In normal mode with 8 PRG bank bits, window 1 uses register 7 and window 3 is bank $FF. Window 0 uses register 6 and window 2 is bank $FE. Select bit 6 exchanges windows 0 and 2. With 6 bank bits, the fixed banks are $3F and $3E.
- R9: In normal mode, CHR windows 0-1 use register 0 and windows 2-3 use register 1. In each case bit 0 of the register is replaced by PPU A10 (after the A12 inversion). Windows 4 to 7 use registers 2 to 5.
- R10: Registers 8 to 11 keep their values while normal mode is active. The mode input acts at once on the outputs.
- R11: A register write shows on the outputs from the clock edge that takes it. During the write cycle the outputs still give the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ext_mode | input | 1 | Extended mode enable from the outer mode register |
| prg_win | input | 2 | CPU A14:A13 of the current PRG access |
| ppu_win | input | 3 | PPU A12:A10 of the current CHR fetch |
| prg_bank | output | PRG_BITS | 8 KiB PRG bank number |
| chr_bank | output | 8 | 1 KiB CHR bank number |

## Verification
A data write and a lookup of the very window that write retargets can land in the same cycle. The question is whether the combinational output gives the old or the new bank. The bench raises a data write while the window inputs point at the target register. It compares the output to the old value before the edge and to the new value one edge later. Mode changes at the same time as bank writes are provoked by random traffic. That traffic toggles `ext_mode` on the cycles that also write through the select and data ports and through the aliases, and a model compares every window afterwards.

// File: rtl/xbank_pkg.sv
// Shared constants and power-on values for the extended bank register file.
// Assumes eight-bit bank registers and a four-bit register index.
package xbank_pkg;
    localparam int NUM_REGS = 12;
    localparam int IDX_W    = 4;
    localparam int VAL_W    = 8;

    typedef logic [VAL_W-1:0] bval_t;

    // Power-on value of bank register i.
    function automatic bval_t reg_init(input int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h02;
            2:       return 8'h04;
            3:       return 8'h05;
            4:       return 8'h06;
            5:       return 8'h07;
            6:       return 8'h00;
            7:       return 8'h01;
            8:       return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/xbank_ctl.sv
// Write port decoder and select register.
// Decodes CPU writes with mask $E003. The select port stores the
// register index and both swap bits. A data port hit becomes a load
// pulse for the register store.
// Assumes cpu_wr is high for one cycle per CPU write.
module xbank_ctl
    import xbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [15:0]      cpu_addr,
    input  logic [7:0]       cpu_wdata,
    output logic             data_we,
    output logic [IDX_W-1:0] sel_idx,
    output logic             prg_swap,
    output logic             chr_swap
);
    localparam logic [15:0] DEC_MASK  = 16'hE003;
    localparam logic [15:0] SEL_PORT  = 16'h8000;
    localparam logic [15:0] DATA_PORT = 16'h8001;

    logic [15:0] masked;
    logic        sel_we;
    logic [7:0]  sel_q;

    // Match the masked address against the two live ports.
    always_comb begin
        masked  = cpu_addr & DEC_MASK;
        sel_we  = cpu_wr && (masked == SEL_PORT);
        data_we = cpu_wr && (masked == DATA_PORT);
    end

    // Select register: reset to zero, load on a select port write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= cpu_wdata;
    end

    assign sel_idx  = sel_q[IDX_W-1:0];
    assign prg_swap = sel_q[6];
    assign chr_swap = sel_q[7];

    // R2: a select port write lands in the select register.
    a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && ((cpu_addr & 16'hE003) == 16'h8000)) |=>
            ({chr_swap, prg_swap, sel_idx} == {$past(cpu_wdata[7:6]), $past(cpu_wdata[3:0])}));
endmodule

// File: rtl/xbank_store.sv
// Twelve bank registers with power-on values.
// Loads the indexed register on a data pulse. An index past the last
// register loads nothing.
// Assumes data_we comes from the port decoder.
module xbank_store
    import xbank_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        data_we,
    input  logic [IDX_W-1:0]            sel_idx,
    input  logic [7:0]                  wdata,
    output logic [NUM_REGS-1:0][VAL_W-1:0] bank_q
);
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            // One bank register: reset value, load when indexed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[i] <= reg_init(i);
                else if (data_we && (sel_idx == IDX_W'(i)))
                    bank_q[i] <= wdata;
            end
        end
    endgenerate

    // R1: first cycle after reset shows the power-on values.
    a_r1_reset_vals: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (bank_q[0] == 8'h00 && bank_q[1] == 8'h02 && bank_q[8] == 8'hFE
                           && bank_q[11] == 8'hFF && bank_q[7] == 8'h01));

    // R4: a data write with an index of 12..15 changes no register.
    a_r4_high_index: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && sel_idx >= 4'd12) |=> $stable(bank_q));

    // R11: an in-range data write is visible after the edge.
    a_r11_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && sel_idx == 4'd6) |=> (bank_q[6] == $past(wdata)));
endmodule

// File: rtl/xbank_prg_map.sv
// Picks the 8 KiB PRG bank for the CPU window A14:A13.
// Normal mode uses registers 6/7 and the last two banks. Extended mode
// uses registers 6..9. The swap bit exchanges windows 0 and 2.
// Assumes PRG_BITS is 6 or 8. Pure combinational.
module xbank_prg_map
    import xbank_pkg::*;
#(
    parameter int PRG_BITS = 8
)(
    input  logic                        ext_mode,
    input  logic                        prg_swap,
    input  logic [1:0]                  prg_win,
    input  logic [NUM_REGS-1:0][VAL_W-1:0] bank_q,
    output logic [PRG_BITS-1:0]         prg_bank
);
    localparam logic [PRG_BITS-1:0] LAST_BANK = '1;
    localparam logic [PRG_BITS-1:0] NEXT_LAST = LAST_BANK - 1'b1;

    logic [PRG_BITS-1:0] r6, r7, r8, r9, swap_lo, swap_hi, fixed_hi;

    // Bank selection per window.
    always_comb begin
        r6 = bank_q[6][PRG_BITS-1:0];
        r7 = bank_q[7][PRG_BITS-1:0];
        r8 = bank_q[8][PRG_BITS-1:0];
        r9 = bank_q[9][PRG_BITS-1:0];
        fixed_hi = ext_mode ? r8 : NEXT_LAST;
        swap_lo  = prg_swap ? fixed_hi : r6;
        swap_hi  = prg_swap ? r6 : fixed_hi;
        case (prg_win)
            2'd0:    prg_bank = swap_lo;
            2'd1:    prg_bank = r7;
            2'd2:    prg_bank = swap_hi;
            default: prg_bank = ext_mode ? r9 : LAST_BANK;
        endcase
    end
endmodule

// File: rtl/xbank_chr_map.sv
// Picks the 1 KiB CHR bank for PPU window A12:A10.
// The swap bit inverts A12 first. Normal mode pairs windows 0-1 and 2-3
// into 2 KiB banks that use A10 as the low bit. Extended mode gives
// every window its own register.
// Pure combinational.
module xbank_chr_map
    import xbank_pkg::*;
(
    input  logic                        ext_mode,
    input  logic                        chr_swap,
    input  logic [2:0]                  ppu_win,
    input  logic [NUM_REGS-1:0][VAL_W-1:0] bank_q,
    output logic [VAL_W-1:0]            chr_bank
);
    logic [2:0] eff;

    // Window after the A12 swap, then per-window source.
    always_comb begin
        eff = {ppu_win[2] ^ chr_swap, ppu_win[1:0]};
        case (eff)
            3'd0:    chr_bank = ext_mode ? bank_q[0]  : {bank_q[0][7:1], 1'b0};
            3'd1:    chr_bank = ext_mode ? bank_q[10] : {bank_q[0][7:1], 1'b1};
            3'd2:    chr_bank = ext_mode ? bank_q[1]  : {bank_q[1][7:1], 1'b0};
            3'd3:    chr_bank = ext_mode ? bank_q[11] : {bank_q[1][7:1], 1'b1};
            3'd4:    chr_bank = bank_q[2];
            3'd5:    chr_bank = bank_q[3];
            3'd6:    chr_bank = bank_q[4];
            default: chr_bank = bank_q[5];
        endcase
    end
endmodule

// File: rtl/xbank_regfile.sv
// Top of the extended bank register file.
// CPU writes come in through the $8000/$8001 ports under mask $E003.
// PRG and CHR bank numbers go out with no delay for the windows given.
// Assumes ext_mode comes from an outer register that resets to 0.
module xbank_regfile
    import xbank_pkg::*;
#(
    parameter int PRG_BITS = 8
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_wr,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                ext_mode,
    input  logic [1:0]          prg_win,
    input  logic [2:0]          ppu_win,
    output logic [PRG_BITS-1:0] prg_bank,
    output logic [7:0]          chr_bank
);
    logic                          data_we;
    logic [IDX_W-1:0]              sel_idx;
    logic                          prg_swap, chr_swap;
    logic [NUM_REGS-1:0][VAL_W-1:0] bank_q;

    xbank_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .data_we(data_we), .sel_idx(sel_idx),
        .prg_swap(prg_swap), .chr_swap(chr_swap)
    );

    xbank_store u_store (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .sel_idx(sel_idx),
        .wdata(cpu_wdata), .bank_q(bank_q)
    );

    xbank_prg_map #(.PRG_BITS(PRG_BITS)) u_prg (
        .ext_mode(ext_mode), .prg_swap(prg_swap), .prg_win(prg_win),
        .bank_q(bank_q), .prg_bank(prg_bank)
    );

    xbank_chr_map u_chr (
        .ext_mode(ext_mode), .chr_swap(chr_swap), .ppu_win(ppu_win),
        .bank_q(bank_q), .chr_bank(chr_bank)
    );

    // R3: writes into the $8002/$8003 holes change no state.
    a_r3_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (((cpu_addr & 16'hE003) == 16'h8002) || ((cpu_addr & 16'hE003) == 16'h8003)))
            |=> ($stable(bank_q) && $stable(sel_idx) && $stable(prg_swap) && $stable(chr_swap)));

    // R8: in normal mode the top CPU window is the last bank.
    a_r8_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && prg_win == 2'b11) |-> (prg_bank == {PRG_BITS{1'b1}}));

    // R9: in normal mode the 2 KiB halves take A10 as the low bit.
    a_r9_chr_a10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && (ppu_win[2] == chr_swap)) |-> (chr_bank[0] == ppu_win[0]));
endmodule

// File: tb/xbank_regfile_bench.sv
// Bench: directed corners plus seeded random traffic, against a model.
module xbank_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic        ext_mode = 1'b0;
    logic [1:0]  prg_win = 2'd0;
    logic [2:0]  ppu_win = 3'd0;
    logic [7:0]  prg_bank;
    logic [7:0]  chr_bank;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m [12];
    logic [7:0] msel;

    always #4 clk = ~clk;

    xbank_regfile u_xbank_regfile (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .ext_mode(ext_mode), .prg_win(prg_win),
        .ppu_win(ppu_win), .prg_bank(prg_bank), .chr_bank(chr_bank)
    );

    task automatic model_reset();
        m[0] = 8'h00; m[1] = 8'h02; m[2] = 8'h04; m[3] = 8'h05;
        m[4] = 8'h06; m[5] = 8'h07; m[6] = 8'h00; m[7] = 8'h01;
        m[8] = 8'hFE; m[9] = 8'hFF; m[10] = 8'hFF; m[11] = 8'hFF;
        msel = 8'h00;
    endtask

    function automatic logic [7:0] exp_prg(input logic [1:0] w);
        logic [7:0] hi;
        hi = ext_mode ? m[8] : 8'hFE;
        case (w)
            2'd0:    return msel[6] ? hi : m[6];
            2'd1:    return m[7];
            2'd2:    return msel[6] ? m[6] : hi;
            default: return ext_mode ? m[9] : 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_chr(input logic [2:0] w);
        logic [2:0] e;
        e = w ^ {msel[7], 2'b00};
        if (ext_mode) begin
            case (e)
                3'd0: return m[0];  3'd1: return m[10];
                3'd2: return m[1];  3'd3: return m[11];
                3'd4: return m[2];  3'd5: return m[3];
                3'd6: return m[4];  default: return m[5];
            endcase
        end
        case (e)
            3'd0, 3'd1: return {m[0][7:1], e[0]};
            3'd2, 3'd3: return {m[1][7:1], e[0]};
            3'd4: return m[2];  3'd5: return m[3];
            3'd6: return m[4];  default: return m[5];
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s prg_win=%0d ppu_win=%0d ext=%0b actual=%02h expected=%02h",
                     tag, prg_win, ppu_win, ext_mode, act, exp);
        end
    endtask

    // Sweep every window; called while the clock is low.
    task automatic check_all(input string ptag, input string ctag);
        for (int w = 0; w < 4; w++) begin
            prg_win = 2'(w); #1;
            check(ptag, prg_bank, exp_prg(2'(w)));
        end
        for (int w = 0; w < 8; w++) begin
            ppu_win = 3'(w); #1;
            check(ctag, chr_bank, exp_chr(3'(w)));
        end
    endtask

    // One CPU write; the model follows the requirements R2, R3, R4.
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] ma;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        ma = a & 16'hE003;
        if (ma == 16'h8000) msel = d;
        else if (ma == 16'h8001 && msel[3:0] < 4'd12) m[msel[3:0]] = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [15:0] pick [7];
        seed = 32'd2024;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state in both modes
        check_all("R1", "R1");
        ext_mode = 1'b1;
        check_all("R1", "R1");
        ext_mode = 1'b0;

        // R2 ports and aliases
        cpu_write(16'h8000, 8'h06); cpu_write(16'h8001, 8'h33);
        check_all("R2", "R2");
        cpu_write(16'h9FFC, 8'h07); cpu_write(16'h9FFD, 8'h21);
        check_all("R2", "R2");
        cpu_write(16'hA001, 8'h80);
        check_all("R2", "R2");

        // R3 holes at $9FFE/$9FFF
        cpu_write(16'h9FFF, 8'hC5); cpu_write(16'h9FFE, 8'h99); cpu_write(16'h8003, 8'h44);
        check_all("R3", "R3");

        // R4 index 12..15 drops data
        cpu_write(16'h8000, 8'h0C); cpu_write(16'h8001, 8'h5A);
        cpu_write(16'h8000, 8'h0F); cpu_write(16'h8001, 8'hA5);
        ext_mode = 1'b1; check_all("R4", "R4"); ext_mode = 1'b0;

        // R10 registers 8..11 loaded in normal mode, used once extended
        cpu_write(16'h8000, 8'h08); cpu_write(16'h8001, 8'h10);
        cpu_write(16'h8000, 8'h09); cpu_write(16'h8001, 8'h11);
        cpu_write(16'h8000, 8'h0A); cpu_write(16'h8001, 8'h12);
        cpu_write(16'h8000, 8'h0B); cpu_write(16'h8001, 8'h13);
        check_all("R8", "R9");
        ext_mode = 1'b1;
        check_all("R10", "R10");

        // R5 R6 R7 swaps in extended mode
        cpu_write(16'h8000, 8'hC0);
        check_all("R7", "R6");
        ext_mode = 1'b0;
        check_all("R8", "R6");

        // R11 write and lookup of the same window in one cycle
        cpu_write(16'h8000, 8'h06);
        prg_win = 2'd0; #1;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 16'h8001; cpu_wdata = 8'h77;
        #1 check("R11", prg_bank, m[6]);
        @(posedge clk); m[6] = 8'h77;
        #1 check("R11", prg_bank, 8'h77);
        @(negedge clk); cpu_wr = 1'b0;

        // Random traffic; covers R5, R7, R8, R9 with mode toggles
        pick[0] = 16'h8000; pick[1] = 16'h8001; pick[2] = 16'h9FFC;
        pick[3] = 16'h9FFD; pick[4] = 16'h8002; pick[5] = 16'h9FFF; pick[6] = 16'hC001;
        for (int it = 0; it < 400; it++) begin
            logic [15:0] a;
            int k;
            k = int'($urandom_range(0, 7));
            a = (k == 7) ? 16'($urandom) : pick[k];
            ext_mode = 1'($urandom);
            cpu_write(a, 8'($urandom));
            if (ext_mode) check_all("R7", "R5");
            else          check_all("R8", "R9");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule